// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Model

This block is a synthesizable model of a 16-bit-wide asynchronous static RAM. It is meant to be the target device in a memory-controller test environment. All control pins are active low: chip select, write strobe, read strobe and one select per byte lane. The model samples them on a free-running clock. The shared data bus is split into three signals: an input word the model samples, an output word, and one drive-enable bit per byte lane. An outer wrapper can join them into a real tri-state bus.

A write lane is open only while chip select, the write strobe and that lane's select are all low. When any of them goes high, the lane closes and commits the bus byte and address taken in the last sample before it closed. Reading needs chip select and the read strobe low with the write strobe high. Only selected lanes are driven, and only after a programmable settling time counted in sample clocks. Address-type changes use one latency and strobe-type changes use a shorter one.

The address width defaults to 8 bits. Set `ADDR_W` to 17 for the full 128K-word device. A standby flag shows when the device is deselected. All outputs are registered.

Top module: `bytelane_sram`

## Requirements
- R1: A lane is written only while `ce_n`, `we_n` and that lane's select are all low. Lane 0 (`be_n[0]`) holds bits 7..0 and lane 1 (`be_n[1]`) holds bits 15..8. A lane whose select stays high keeps its stored byte.
- R2: A write lane commits when it closes. It stores the `dq_in` byte and the `addr` from the last sample in which it was still open. This holds whichever of chip select, write strobe or lane select ends it, and each lane closes independently.
- R3: While reading (`ce_n`=0, `oe_n`=0, `we_n`=1) and settled, `dq_oe[l]`=1 exactly for lanes with `be_n[l]`=0. The matching `dq_out` byte then holds the stored byte and undriven bytes read 0.
- R4: `dq_oe` is all zero whenever `ce_n`=1, `oe_n`=1, both lane selects are 1, or a write strobe is active (`ce_n`=0 and `we_n`=0).
- R5: Suppose a change of `addr`, a falling `ce_n` or a rising `we_n` is first sampled at rising edge k. Then no lane drives through edge k+ADDR_LAT-1, and a valid read drives from edge k+ADDR_LAT.
- R6: Suppose a falling `oe_n` or a falling lane select is first sampled at edge k, with nothing else changing. Then no lane drives through edge k+OE_LAT-1, and drive starts at edge k+OE_LAT.
- R7: `standby` is 1 one edge after `ce_n`=1 or both lane selects=1 is sampled, and 0 otherwise.
- R8: When `ce_n` and `we_n` rise in the same sample, no lane drives in that or any later cycle while `ce_n` stays high.
- R9: Synchronous reset clears `dq_oe` and `dq_out` and sets `standby`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| be_n | input | LANES | Lane selects, active low; bit 0 = low byte |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*8 | Bus value as seen by the model |
| dq_out | output | LANES*8 | Data the model drives |
| dq_oe | output | LANES | Per-lane drive enable |
| standby | output | 1 | Deselected / power-down indication |

## Verification
Every word of a 16-word configuration is written with a full-word pattern and read back. Then alternating single-lane writes are read back; their merged result shows that each lane select reaches only its own byte. All 32 combinations of the five control pins are swept on a fixed word and compared against the per-lane drive rule and the standby rule. Writing the word's own value back keeps the stored data unchanged, so this sweep separates the drive logic from the storage. Directed sequences check three more behaviours:
- write windows closed by a lane select, by chip select and by an address moved mid-window, which shows which sample is committed;
- reads whose start is blanked by address versus strobe edges, where the two differing latencies show which trigger was applied;
- a joint release of chip select and write strobe.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_write_window.sv
module sram_write_window
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ce_n,
  input  logic                              we_n,
  input  logic [LANES-1:0]                  be_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [LANES*LANE_W-1:0]           din,
  output logic [LANES-1:0]                  wr_en,
  output logic [LANES-1:0][ADDR_W-1:0]      wr_addr,
  output logic [LANES-1:0][LANE_W-1:0]      wr_data
);
  // Each lane tracks its own overlap window; commit happens on the sample
  // in which the window is first seen closed.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              open_now;
    logic              open_q;
    logic [ADDR_W-1:0] a_q;
    logic [LANE_W-1:0] d_q;

    assign open_now = ~ce_n & ~we_n & ~be_n[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        open_q <= 1'b0;
        a_q    <= '0;
        d_q    <= '0;
      end else begin
        open_q <= open_now;
        if (open_now) begin
          a_q <= addr;
          d_q <= din[g*LANE_W +: LANE_W];
        end
      end
    end

    assign wr_en[g]   = open_q & ~open_now;
    assign wr_addr[g] = a_q;
    assign wr_data[g] = d_q;
  end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                         clk,
  input  logic [LANES-1:0]             wr_en,
  input  logic [LANES-1:0][ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0][LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [LANES-1:0][LANE_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // One simple-dual-port array per lane: one write port, one registered read.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[wr_addr[g]] <= wr_data[g];
      q <= mem[rd_addr];
    end

    assign rd_data[g] = q;
  end
endmodule

// File: rtl/sram_read_timer.sv
module sram_read_timer
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_LAT = 3,
  parameter int unsigned OE_LAT   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_addr,
  input  logic trig_en,
  output logic settled
);
  localparam int unsigned TOP = max_u(ADDR_LAT, OE_LAT);
  localparam int unsigned CW  = $clog2(TOP + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dec;
  logic [CW-1:0] cnt_d;

  // Count down; each trigger can only lengthen the remaining wait.
  always_comb begin
    dec   = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
    cnt_d = dec;
    if (trig_en && (CW'(OE_LAT) > cnt_d))     cnt_d = CW'(OE_LAT);
    if (trig_addr && (CW'(ADDR_LAT) > cnt_d)) cnt_d = CW'(ADDR_LAT);
    settled = (cnt_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned LANES    = 2,
  parameter int unsigned ADDR_LAT = 3,
  parameter int unsigned OE_LAT   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [LANES-1:0]          be_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic [LANES-1:0]          dq_oe,
  output logic                      standby
);
  // ADDR_LAT must be at least 2 so a read never sees the array before a
  // write committed on the same edge has landed.

  logic [LANES-1:0]                  wr_en;
  logic [LANES-1:0][ADDR_W-1:0]      wr_addr;
  logic [LANES-1:0][LANE_W-1:0]      wr_data;
  logic [LANES-1:0][LANE_W-1:0]      rd_data;

  logic [ADDR_W-1:0] addr_p;
  logic              ce_p, we_p, oe_p;
  logic [LANES-1:0]  be_p;
  logic              trig_addr, trig_en, settled, read_ok;
  logic [LANES-1:0]  drive;

  sram_write_window #(.ADDR_W(ADDR_W), .LANES(LANES)) u_win (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .be_n(be_n),
    .addr(addr), .din(dq_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sram_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr), .rd_data(rd_data)
  );

  sram_read_timer #(.ADDR_LAT(ADDR_LAT), .OE_LAT(OE_LAT)) u_timer (
    .clk(clk), .rst(rst), .trig_addr(trig_addr), .trig_en(trig_en),
    .settled(settled)
  );

  // Previous-sample copies used for edge detection on the controls.
  always_ff @(posedge clk) begin
    addr_p <= addr;
    if (rst) begin
      ce_p <= 1'b1;
      we_p <= 1'b1;
      oe_p <= 1'b1;
      be_p <= '1;
    end else begin
      ce_p <= ce_n;
      we_p <= we_n;
      oe_p <= oe_n;
      be_p <= be_n;
    end
  end

  always_comb begin
    trig_addr = (addr != addr_p) | (ce_p & ~ce_n) | (~we_p & we_n);
    trig_en   = (oe_p & ~oe_n) | (|(be_p & ~be_n));
    read_ok   = ~ce_n & ~oe_n & we_n;
    drive     = (read_ok && settled) ? ~be_n : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe   <= '0;
      dq_out  <= '0;
      standby <= 1'b1;
    end else begin
      dq_oe   <= drive;
      standby <= ce_n | (&be_n);
      for (int l = 0; l < LANES; l++) begin
        dq_out[l*LANE_W +: LANE_W] <= drive[l] ? rd_data[l] : '0;
      end
    end
  end
endmodule

// File: rtl/sram_model_checker.sv
module sram_model_checker
  import sram_model_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce_n,
  input logic                    we_n,
  input logic                    oe_n,
  input logic [LANES-1:0]        be_n,
  input logic [ADDR_W-1:0]       addr,
  input logic [LANES*LANE_W-1:0] dq_out,
  input logic [LANES-1:0]        dq_oe,
  input logic                    standby
);
  a_r4_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !we_n || (&be_n)) |=> (dq_oe == '0));

  a_r3_lane_needs_select: assert property (@(posedge clk) disable iff (rst)
    (|be_n) |=> ((dq_oe & $past(be_n)) == '0));

  a_r5_addr_change_blanks: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |=> (dq_oe == '0));

  a_r7_standby_set: assert property (@(posedge clk) disable iff (rst)
    (ce_n || (&be_n)) |=> standby);

  a_r7_standby_clear: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !(&be_n)) |=> !standby);

  a_r8_joint_release: assert property (@(posedge clk) disable iff (rst)
    ($rose(ce_n) && $rose(we_n)) |=> (dq_oe == '0));

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> ((dq_oe == '0) && (dq_out == '0) && standby));
endmodule

bind bytelane_sram sram_model_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .be_n(be_n),
  .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby)
);

// File: tb/bytelane_sram_bench.sv
`timescale 1ns/1ps
module bytelane_sram_bench;
  localparam int unsigned AW    = 4;
  localparam int unsigned LAT_A = 3;
  localparam int unsigned LAT_E = 2;
  localparam int unsigned WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]    be_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out;
  logic [1:0]    dq_oe;
  logic          standby;

  logic [15:0]   exp_mem [WORDS];
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 1'b0;

  always #4 clk = ~clk;

  bytelane_sram #(.ADDR_W(AW), .LANES(2), .ADDR_LAT(LAT_A), .OE_LAT(LAT_E)) u_bytelane_sram (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .be_n(be_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_bus(input logic c, input logic w, input logic o, input logic [1:0] b,
                         input logic [AW-1:0] a, input logic [15:0] d);
    ce_n = c; we_n = w; oe_n = o; be_n = b; addr = a; dq_in = d;
  endtask

  task automatic go_idle();
    set_bus(1'b1, 1'b1, 1'b1, 2'b11, addr, dq_in);
    tick(1);
  endtask

  function automatic logic [15:0] lane_view(input logic [15:0] w, input logic [1:0] b);
    return {(b[1] ? 8'h00 : w[15:8]), (b[0] ? 8'h00 : w[7:0])};
  endfunction

  // Write window closed by the write strobe while chip select stays low.
  task automatic write_word(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] b);
    set_bus(1'b0, 1'b0, 1'b1, b, a, d);
    tick(2);
    we_n = 1'b1;
    tick(1);
    if (!b[0]) exp_mem[a][7:0]  = d[7:0];
    if (!b[1]) exp_mem[a][15:8] = d[15:8];
    go_idle();
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [1:0] b, input string tag);
    set_bus(1'b0, 1'b1, 1'b0, b, a, 16'h0000);
    tick(LAT_A + 1);
    check(dq_oe == ~b, tag, {30'd0, dq_oe}, {30'd0, ~b});
    check(dq_out == lane_view(exp_mem[a], b), tag, {16'd0, dq_out}, {16'd0, lane_view(exp_mem[a], b)});
    go_idle();
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h1357 + 16'h2468);
  endfunction

  initial begin
    for (int i = 0; i < int'(WORDS); i++) exp_mem[i] = 16'h0000;
    tick(3);
    // R9: reset state
    check(dq_oe == 2'b00, "R9 oe", {30'd0, dq_oe}, 32'd0);
    check(dq_out == 16'h0000, "R9 data", {16'd0, dq_out}, 32'd0);
    check(standby == 1'b1, "R9 standby", {31'd0, standby}, 32'd1);
    rst = 1'b0;
    tick(1);

    // R1/R3: full-word sweep of every address
    for (int a = 0; a < int'(WORDS); a++) write_word(AW'(a), pat(a), 2'b00);
    for (int a = 0; a < int'(WORDS); a++) read_expect(AW'(a), 2'b00, "R1 full");

    // R1: single-lane writes, low lane at even words, high lane at odd words
    for (int a = 0; a < int'(WORDS); a++)
      write_word(AW'(a), ~pat(a), (a % 2 == 0) ? 2'b10 : 2'b01);
    for (int a = 0; a < int'(WORDS); a++) read_expect(AW'(a), 2'b00, "R1 lane merge");
    // R3: single-lane reads
    for (int a = 0; a < int'(WORDS); a++) read_expect(AW'(a), 2'b10, "R3 low lane");
    for (int a = 0; a < int'(WORDS); a++) read_expect(AW'(a), 2'b01, "R3 high lane");

    // R4/R7/R3: all control combinations on word 15, bus holds its own value
    for (int c = 0; c < 32; c++) begin
      logic [1:0] b;
      logic [1:0] eo;
      logic       es;
      b = c[1:0];
      go_idle();
      set_bus(c[4], c[3], c[2], b, AW'(WORDS - 1), exp_mem[WORDS-1]);
      tick(LAT_A + 1);
      eo = (!c[4] && c[3] && !c[2]) ? ~b : 2'b00;
      es = c[4] | (&b);
      check(dq_oe == eo, "R4 truth table", {27'd0, 5'(c)}, {30'd0, eo});
      check(standby == es, "R7 standby", {31'd0, standby}, {31'd0, es});
      if (eo != 2'b00)
        check(dq_out == lane_view(exp_mem[WORDS-1], b), "R3 sweep data",
              {16'd0, dq_out}, {16'd0, lane_view(exp_mem[WORDS-1], b)});
      go_idle();
    end
    read_expect(AW'(WORDS - 1), 2'b00, "R4 word kept");

    // R2: lane 0 closed by its select, lane 1 closed by chip select
    set_bus(1'b0, 1'b0, 1'b1, 2'b00, AW'(5), 16'hA1B2); tick(1);
    dq_in = 16'hC3D4; tick(1);
    be_n = 2'b01; dq_in = 16'hE5F6; tick(1);
    ce_n = 1'b1; dq_in = 16'h0789; tick(1);
    exp_mem[5] = 16'hE5D4;
    go_idle();
    read_expect(AW'(5), 2'b00, "R2 split close");

    // R2: address moved mid-window, closed by write strobe
    set_bus(1'b0, 1'b0, 1'b1, 2'b00, AW'(7), 16'h1111); tick(1);
    addr = AW'(8); dq_in = 16'h2222; tick(1);
    we_n = 1'b1; tick(1);
    exp_mem[8] = 16'h2222;
    go_idle();
    read_expect(AW'(8), 2'b00, "R2 last address");
    read_expect(AW'(7), 2'b00, "R2 earlier address untouched");

    // R8: chip select and write strobe released together with read strobe low
    set_bus(1'b0, 1'b0, 1'b0, 2'b00, AW'(6), 16'h5A5A);
    tick(2);
    check(dq_oe == 2'b00, "R4 during write", {30'd0, dq_oe}, 32'd0);
    ce_n = 1'b1; we_n = 1'b1;
    tick(1);
    check(dq_oe == 2'b00, "R8 release", {30'd0, dq_oe}, 32'd0);
    tick(LAT_A);
    check(dq_oe == 2'b00, "R8 after release", {30'd0, dq_oe}, 32'd0);
    exp_mem[6] = 16'h5A5A;
    go_idle();
    read_expect(AW'(6), 2'b00, "R8 write kept");

    // R5: address-type latency
    set_bus(1'b0, 1'b1, 1'b0, 2'b00, AW'(3), 16'h0000);
    tick(LAT_A);
    check(dq_oe == 2'b00, "R5 select blank", {30'd0, dq_oe}, 32'd0);
    tick(1);
    check(dq_oe == 2'b11, "R5 select drive", {30'd0, dq_oe}, 32'd3);
    check(dq_out == exp_mem[3], "R5 data", {16'd0, dq_out}, {16'd0, exp_mem[3]});
    addr = AW'(4);
    tick(LAT_A);
    check(dq_oe == 2'b00, "R5 address blank", {30'd0, dq_oe}, 32'd0);
    tick(1);
    check(dq_out == exp_mem[4] && dq_oe == 2'b11, "R5 address drive",
          {16'd0, dq_out}, {16'd0, exp_mem[4]});

    // R6: strobe-type latency
    oe_n = 1'b1; tick(2);
    check(dq_oe == 2'b00, "R4 read strobe high", {30'd0, dq_oe}, 32'd0);
    oe_n = 1'b0; tick(LAT_E);
    check(dq_oe == 2'b00, "R6 strobe blank", {30'd0, dq_oe}, 32'd0);
    tick(1);
    check(dq_oe == 2'b11, "R6 strobe drive", {30'd0, dq_oe}, 32'd3);
    be_n = 2'b11; tick(2);
    check(dq_oe == 2'b00 && standby, "R7 both lanes off", {30'd0, dq_oe}, 32'd0);
    be_n = 2'b01; tick(LAT_E);
    check(dq_oe == 2'b00, "R6 lane blank", {30'd0, dq_oe}, 32'd0);
    tick(1);
    check(dq_oe == 2'b10 && !standby, "R6 lane drive", {30'd0, dq_oe}, 32'd2);
    check(dq_out == lane_view(exp_mem[4], 2'b01), "R6 lane data",
          {16'd0, dq_out}, {16'd0, lane_view(exp_mem[4], 2'b01)});
    go_idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule